// File: doc/BRIEF.md
# Coherence Response Classifier with Acknowledgement Counter

This block sits at the response input of a private cache controller. Each response message arrives with a type, a flag giving the sender class (a peer first-level cache or the shared second-level bank), a signed acknowledgement count, a destination node ID and the current state of the addressed line. The block sorts the message into one controller event. The miss handler acts on that event.

The block holds one transaction-buffer entry. The entry keeps a signed pending-acknowledgement counter and a copy of the line's data and dirty bit, both captured when the entry is allocated. Completion is decided by whether the pending count minus the carried count reaches zero. When a data or acknowledgement message is classified, the counter is reduced by the carried count. A data message can carry a negative count. It then raises the counter to the number of acknowledgements still expected, and each later invalidate acknowledgement (which carries 1) brings the counter down to zero.

The entry is a two-state machine: FREE and BUSY. The transition alloc goes FREE/BUSY→BUSY, clears the counter and captures the data and dirty bit. The transition release goes BUSY→FREE. Results are registered and appear one cycle after the message.

Top module: `coh_resp_classifier`

## Requirements
- R1: A valid message for this node with type code 0 (exclusive data) yields event code 0 on the next cycle, whatever the line state, sender or entry state, and leaves the counter unchanged.
- R2: A type-1 (data) message from a peer (`rsp_from_peer`=1) while `line_state` is 1 (read miss outstanding) or 2 (read miss outstanding, invalidated) yields event code 1 and leaves the counter unchanged.
- R3: Any other type-1 message yields event code 3 (data, all acks) when pending minus carried is zero, and code 2 otherwise.
- R4: A type-2 (ack) message yields event code 5 (last ack) when pending minus carried is zero, and code 4 otherwise.
- R5: A type-3 message yields event code 6 (writeback ack). Type codes 4 to 7 raise `rsp_err` with no event.
- R6: Classification into codes 2 to 5 subtracts the signed carried count from the signed pending counter on the same edge as the event.
- R7: An alloc clears the counter to zero, moves the entry to BUSY, and captures `alloc_data` and `alloc_dirty` on the output hold registers.
- R8: A message whose destination differs from NODE_ID raises `rsp_err`, gives no event and leaves the counter unchanged.
- R9: A message needing the counter (codes 2 to 5) while the entry is FREE raises `rsp_err`, gives no event, and leaves the counter unchanged. The release transition returns the entry to FREE.
- R10: Without a message or alloc in a cycle, the counter keeps its value, and `evt_valid` and `rsp_err` are both low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate the entry |
| alloc_data | input | DATA_W | Line data captured on alloc |
| alloc_dirty | input | 1 | Line dirty bit captured on alloc |
| release_valid | input | 1 | Free the entry |
| rsp_valid | input | 1 | Response message present |
| rsp_kind | input | 3 | Message type code |
| rsp_from_peer | input | 1 | 1 = sent by a peer L1, 0 = by the L2 bank |
| rsp_acks | input | CNT_W | Signed carried acknowledgement count |
| rsp_dest | input | ID_W | Destination node ID |
| line_state | input | 3 | Current line state code |
| evt_valid | output | 1 | Event produced |
| evt_code | output | 3 | Event code |
| rsp_err | output | 1 | Message rejected |
| pending_acks | output | CNT_W | Signed pending counter |
| held_data | output | DATA_W | Data held in the entry |
| held_dirty | output | 1 | Dirty bit held in the entry |
| entry_busy | output | 1 | Entry is in BUSY |

## Verification
The assertions assume that alloc and a response never arrive in the same cycle. They also assume that alloc and release are never raised together, so each counter change has a single cause. The bench drives at most one of these per cycle and follows every stimulus cycle with an idle cycle. Sequences cover negative carried counts, acknowledgements that push the counter below zero, and messages that must be rejected while the entry is FREE.

// File: rtl/coh_rsp_pkg.sv
package coh_rsp_pkg;
    typedef enum logic [2:0] {
        RK_DATA_EXCL = 3'd0,
        RK_DATA      = 3'd1,
        RK_ACK       = 3'd2,
        RK_WB_ACK    = 3'd3
    } rsp_kind_e;

    typedef enum logic [2:0] {
        EV_DATA_EXCL = 3'd0,
        EV_DATA_PEER = 3'd1,
        EV_DATA      = 3'd2,
        EV_DATA_ALL  = 3'd3,
        EV_ACK       = 3'd4,
        EV_ACK_LAST  = 3'd5,
        EV_WB_ACK    = 3'd6
    } evt_e;

    localparam logic [2:0] LS_RD_WAIT     = 3'd1;
    localparam logic [2:0] LS_RD_WAIT_INV = 3'd2;

    typedef enum logic {
        ST_FREE = 1'b0,
        ST_BUSY = 1'b1
    } entry_st_e;
endpackage

// File: rtl/coh_rsp_decode.sv
module coh_rsp_decode
    import coh_rsp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [2:0]              kind,
    input  logic                    from_peer,
    input  logic [2:0]              line_st,
    input  logic signed [CNT_W-1:0] pending,
    input  logic signed [CNT_W-1:0] carried,
    input  logic                    dest_ok,
    input  logic                    busy,
    output evt_e                    evt,
    output logic                    evt_ok,
    output logic                    bad,
    output logic                    upd
);
    logic signed [CNT_W-1:0] remain;
    logic                    done;
    logic                    rd_wait;

    assign remain  = pending - carried;
    assign done    = (remain == '0);
    assign rd_wait = (line_st == LS_RD_WAIT) || (line_st == LS_RD_WAIT_INV);

    always_comb begin
        evt    = EV_DATA_EXCL;
        evt_ok = 1'b0;
        bad    = 1'b0;
        upd    = 1'b0;
        if (!dest_ok) begin
            bad = 1'b1;
        end else begin
            unique case (kind)
                RK_DATA_EXCL: begin
                    evt = EV_DATA_EXCL; evt_ok = 1'b1;
                end
                RK_DATA: begin
                    if (from_peer && rd_wait) begin
                        evt = EV_DATA_PEER; evt_ok = 1'b1;
                    end else if (!busy) begin
                        bad = 1'b1;
                    end else begin
                        evt = done ? EV_DATA_ALL : EV_DATA;
                        evt_ok = 1'b1; upd = 1'b1;
                    end
                end
                RK_ACK: begin
                    if (!busy) begin
                        bad = 1'b1;
                    end else begin
                        evt = done ? EV_ACK_LAST : EV_ACK;
                        evt_ok = 1'b1; upd = 1'b1;
                    end
                end
                RK_WB_ACK: begin
                    evt = EV_WB_ACK; evt_ok = 1'b1;
                end
                default: bad = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/coh_rsp_entry.sv
module coh_rsp_entry
    import coh_rsp_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc,
    input  logic [DATA_W-1:0]       alloc_data,
    input  logic                    alloc_dirty,
    input  logic                    release_req,
    input  logic                    upd,
    input  logic signed [CNT_W-1:0] carried,
    output logic signed [CNT_W-1:0] pending,
    output logic [DATA_W-1:0]       data,
    output logic                    dirty,
    output logic                    busy
);
    entry_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_FREE: if (alloc) st_d = ST_BUSY;
            ST_BUSY: if (!alloc && release_req) st_d = ST_FREE;
            default: st_d = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_FREE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            data    <= '0;
            dirty   <= 1'b0;
        end else if (alloc) begin
            pending <= '0;
            data    <= alloc_data;
            dirty   <= alloc_dirty;
        end else if (upd) begin
            pending <= pending - carried;
        end
    end

    assign busy = (st_q == ST_BUSY);
endmodule

// File: rtl/coh_resp_classifier.sv
module coh_resp_classifier
    import coh_rsp_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int DATA_W  = 32,
    parameter int ID_W    = 4,
    parameter int NODE_ID = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic [DATA_W-1:0]       alloc_data,
    input  logic                    alloc_dirty,
    input  logic                    release_valid,
    input  logic                    rsp_valid,
    input  logic [2:0]              rsp_kind,
    input  logic                    rsp_from_peer,
    input  logic signed [CNT_W-1:0] rsp_acks,
    input  logic [ID_W-1:0]         rsp_dest,
    input  logic [2:0]              line_state,
    output logic                    evt_valid,
    output logic [2:0]              evt_code,
    output logic                    rsp_err,
    output logic signed [CNT_W-1:0] pending_acks,
    output logic [DATA_W-1:0]       held_data,
    output logic                    held_dirty,
    output logic                    entry_busy
);
    localparam logic [ID_W-1:0] MY_ID = ID_W'(NODE_ID);

    evt_e dec_evt;
    logic dec_ok, dec_bad, dec_upd, dest_ok;

    assign dest_ok = (rsp_dest == MY_ID);

    coh_rsp_decode #(.CNT_W(CNT_W)) u_dec (
        .kind(rsp_kind), .from_peer(rsp_from_peer), .line_st(line_state),
        .pending(pending_acks), .carried(rsp_acks), .dest_ok(dest_ok),
        .busy(entry_busy), .evt(dec_evt), .evt_ok(dec_ok), .bad(dec_bad),
        .upd(dec_upd)
    );

    coh_rsp_entry #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ent (
        .clk(clk), .rst_n(rst_n), .alloc(alloc_valid), .alloc_data(alloc_data),
        .alloc_dirty(alloc_dirty), .release_req(release_valid),
        .upd(rsp_valid && dec_upd), .carried(rsp_acks), .pending(pending_acks),
        .data(held_data), .dirty(held_dirty), .busy(entry_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= 3'd0;
            rsp_err   <= 1'b0;
        end else begin
            evt_valid <= rsp_valid && dec_ok;
            evt_code  <= dec_evt;
            rsp_err   <= rsp_valid && dec_bad;
        end
    end
endmodule

// File: rtl/coh_rsp_checker.sv
module coh_rsp_checker #(
    parameter int CNT_W   = 8,
    parameter int ID_W    = 4,
    parameter int NODE_ID = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    alloc_valid,
    input logic                    rsp_valid,
    input logic [2:0]              rsp_kind,
    input logic [ID_W-1:0]         rsp_dest,
    input logic                    evt_valid,
    input logic [2:0]              evt_code,
    input logic                    rsp_err,
    input logic signed [CNT_W-1:0] pending_acks,
    input logic                    entry_busy
);
    assert_excl_evt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_dest == ID_W'(NODE_ID) && rsp_kind == 3'd0
        |=> evt_valid && evt_code == 3'd0);

    assert_last_ack_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_code == 3'd5 |-> pending_acks == '0);

    assert_wb_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_dest == ID_W'(NODE_ID) && rsp_kind == 3'd3
        |=> evt_valid && evt_code == 3'd6);

    assert_alloc_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_valid |=> pending_acks == '0 && entry_busy);

    assert_dest_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_dest != ID_W'(NODE_ID)
        |=> rsp_err && !evt_valid && $stable(pending_acks));

    assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid && !alloc_valid
        |=> $stable(pending_acks) && !evt_valid && !rsp_err);
endmodule

bind coh_resp_classifier coh_rsp_checker #(
    .CNT_W(CNT_W), .ID_W(ID_W), .NODE_ID(NODE_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .rsp_valid(rsp_valid),
    .rsp_kind(rsp_kind), .rsp_dest(rsp_dest), .evt_valid(evt_valid),
    .evt_code(evt_code), .rsp_err(rsp_err), .pending_acks(pending_acks),
    .entry_busy(entry_busy)
);

// File: tb/tb_coh_resp_classifier.sv
module tb_coh_resp_classifier;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8, DATA_W = 32, ID_W = 4, NODE_ID = 5;

    typedef struct packed {
        logic                    v;
        logic                    e;
        logic [2:0]              c;
        logic signed [CNT_W-1:0] p;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, alloc_dirty = 0, release_valid = 0;
    logic [DATA_W-1:0] alloc_data = '0;
    logic rsp_valid = 0, rsp_from_peer = 0;
    logic [2:0] rsp_kind = '0, line_state = '0;
    logic signed [CNT_W-1:0] rsp_acks = '0;
    logic [ID_W-1:0] rsp_dest = '0;
    logic evt_valid, rsp_err, held_dirty, entry_busy;
    logic [2:0] evt_code;
    logic signed [CNT_W-1:0] pending_acks;
    logic [DATA_W-1:0] held_data;

    int errors = 0, checks = 0;
    bit done = 0;
    exp_t exp_q[$];
    string tag_q[$];
    logic signed [CNT_W-1:0] m_pend = '0;
    bit m_busy = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_resp_classifier #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ID_W(ID_W), .NODE_ID(NODE_ID)) dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_data(alloc_data),
        .alloc_dirty(alloc_dirty), .release_valid(release_valid), .rsp_valid(rsp_valid),
        .rsp_kind(rsp_kind), .rsp_from_peer(rsp_from_peer), .rsp_acks(rsp_acks),
        .rsp_dest(rsp_dest), .line_state(line_state), .evt_valid(evt_valid),
        .evt_code(evt_code), .rsp_err(rsp_err), .pending_acks(pending_acks),
        .held_data(held_data), .held_dirty(held_dirty), .entry_busy(entry_busy)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input exp_t x, input string tag);
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        rsp_valid = 0; alloc_valid = 0; release_valid = 0;
        push('{v: 1'b0, e: 1'b0, c: 3'd0, p: m_pend}, tag);
    endtask

    task automatic send(input logic [2:0] kind, input logic peer, input int acks,
                        input int dest, input logic [2:0] ls, input string tag);
        exp_t x;
        logic signed [CNT_W-1:0] rem;
        x = '{v: 1'b0, e: 1'b0, c: 3'd0, p: m_pend};
        rem = m_pend - CNT_W'(acks);
        if (dest != NODE_ID) x.e = 1;
        else case (kind)
            3'd0: begin x.v = 1; x.c = 3'd0; end
            3'd1: if (peer && (ls == 3'd1 || ls == 3'd2)) begin x.v = 1; x.c = 3'd1; end
                  else if (!m_busy) x.e = 1;
                  else begin x.v = 1; x.c = (rem == 0) ? 3'd3 : 3'd2; m_pend = rem; end
            3'd2: if (!m_busy) x.e = 1;
                  else begin x.v = 1; x.c = (rem == 0) ? 3'd5 : 3'd4; m_pend = rem; end
            3'd3: begin x.v = 1; x.c = 3'd6; end
            default: x.e = 1;
        endcase
        x.p = m_pend;
        @(negedge clk);
        rsp_valid = 1; rsp_kind = kind; rsp_from_peer = peer;
        rsp_acks = CNT_W'(acks); rsp_dest = ID_W'(dest); line_state = ls;
        push(x, tag);
        idle({tag, " idle"});
    endtask

    task automatic do_alloc(input logic [DATA_W-1:0] d, input logic dty);
        @(negedge clk);
        alloc_valid = 1; alloc_data = d; alloc_dirty = dty;
        m_pend = '0; m_busy = 1;
        push('{v: 1'b0, e: 1'b0, c: 3'd0, p: m_pend}, "R7 alloc");
        idle("R7 alloc idle");
        check("R7 held_data", 64'(held_data), 64'(d));
        check("R7 held_dirty", 64'(held_dirty), 64'(dty));
        check("R7 busy", 64'(entry_busy), 64'd1);
    endtask

    task automatic do_release();
        @(negedge clk);
        release_valid = 1; m_busy = 0;
        push('{v: 1'b0, e: 1'b0, c: 3'd0, p: m_pend}, "R9 release");
        idle("R9 release idle");
        check("R9 busy after release", 64'(entry_busy), 64'd0);
    endtask

    // Monitor: pops one expectation per clock edge, samples after the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " evt_valid"}, 64'(evt_valid), 64'(x.v));
                check({t, " rsp_err"}, 64'(rsp_err), 64'(x.e));
                if (x.v) check({t, " evt_code"}, 64'(evt_code), 64'(x.c));
                check({t, " pending"}, 64'(pending_acks), 64'(x.p));
            end
        end
    end

    initial begin
        repeat (CLK_PERIOD * 2000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R10 reset evt_valid", 64'(evt_valid), 64'd0);
        check("R10 reset err", 64'(rsp_err), 64'd0);
        check("R10 reset pending", 64'(pending_acks), 64'd0);
        check("R9 reset busy", 64'(entry_busy), 64'd0);

        send(3'd0, 1'b0, 0, NODE_ID, 3'd0, "R1 excl data free entry");
        send(3'd3, 1'b0, 0, NODE_ID, 3'd4, "R5 wb ack");
        send(3'd2, 1'b0, 1, NODE_ID, 3'd0, "R9 ack while free");
        send(3'd1, 1'b0, 0, NODE_ID, 3'd0, "R9 data while free");
        do_alloc(32'hA5A5_0F0F, 1'b1);
        send(3'd1, 1'b1, 4, NODE_ID, 3'd1, "R2 peer data rd_wait");
        send(3'd1, 1'b1, 4, NODE_ID, 3'd2, "R2 peer data rd_wait_inv");
        send(3'd1, 1'b0, 0, NODE_ID, 3'd1, "R3 l2 data all acks");
        send(3'd1, 1'b1, -2, NODE_ID, 3'd3, "R3 R6 peer data other state neg count");
        send(3'd2, 1'b0, 1, NODE_ID, 3'd3, "R4 ack not last");
        send(3'd2, 1'b1, 1, NODE_ID, 3'd3, "R4 last ack");
        send(3'd2, 1'b0, 3, NODE_ID, 3'd3, "R6 ack below zero");
        send(3'd1, 1'b0, -3, NODE_ID, 3'd3, "R3 R6 data returns to zero");
        send(3'd0, 1'b1, 7, NODE_ID, 3'd1, "R1 excl data ignores count");
        send(3'd2, 1'b0, 1, NODE_ID + 1, 3'd3, "R8 dest mismatch ack");
        send(3'd0, 1'b0, 0, 0, 3'd0, "R8 dest mismatch excl");
        send(3'd5, 1'b0, 1, NODE_ID, 3'd0, "R5 bad type 5");
        send(3'd7, 1'b0, 1, NODE_ID, 3'd0, "R5 bad type 7");
        do_alloc(32'h1234_5678, 1'b0);
        send(3'd2, 1'b0, 0, NODE_ID, 3'd0, "R4 zero count ack is last");
        do_release();
        send(3'd2, 1'b0, 1, NODE_ID, 3'd0, "R9 ack after release");
        idle("R10 quiet");
        idle("R10 quiet 2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule